// File: doc/BRIEF.md
# Scratchpad Write and Verify Controller

This block sits between a byte-level serial memory command layer and a nonvolatile byte array. It holds a 32-byte volatile staging buffer. A write command is followed by a two-byte target address, low byte first, and then by data bytes. The high address bits are masked as they arrive. Each data byte lands at the next buffer slot, starting from the slot given by the low address bits. Before it is stored, a byte may be replaced or merged with the contents already in the array, depending on the protection setting of the 256-byte block being addressed.

A read command returns the information the host needs to check what was staged:

- the captured target address;
- a status byte with the last written slot and two flags;
- the buffer contents from the start slot up to the last slot;
- an inverted CRC16 over everything sent so far;
- all-ones bytes after that.

The array itself is external. It is a synchronous memory with one cycle of read latency, and the block drives its address continuously.

Top module: `scpad_ctrl`

## Requirements
- R1: When the high address byte is captured, its upper four bits are cleared, so target addresses above 0FFFh are read back with those bits at zero.
- R2: The first data byte is stored at the slot given by address bits 4:0. Each further byte goes to the next slot. Bytes that arrive after slot 31 has been written are ignored.
- R3: A write command clears the partial flag (status bit 5) and the authorization flag (status bit 7). A pulse on `auth_set` sets the authorization flag.
- R4: The partial flag is 1 after power-up reset. It is set when a bus reset arrives while the target address is incomplete.
- R5: A bus reset with `rx_partial` high during the data phase sets the partial flag. The unfinished byte is not stored.
- R6: In a write-protected block, each stored byte equals the array byte at that address, whatever byte was sent.
- R7: In a one-way block, the stored byte is the array byte ANDed with the sent byte, so bits can only go from 1 to 0. Write protection takes priority when both settings are on.
- R8: A read command (code AAh) returns these bytes in order, one per `tx_next`: address low, address high, status, then buffer slots from the start slot through slot 31.
- R9: After the data, the read returns the CRC16 in two bytes, low byte first. The CRC uses polynomial x^16+x^15+x^2+1, a zero seed and LSB-first processing, covers the command byte and every byte sent, and is inverted. After the CRC, every byte is FFh.
- R10: Status byte layout: bits 4:0 hold the slot of the last stored byte (the start slot when no byte has been stored), bit 5 the partial flag, bit 6 zero, bit 7 the authorization flag.
- R11: Protection is chosen per 256-byte block by address bits 11:8. Blocks numbered `NBLK` or higher are never protected.
- R12: `tx_byte` is FFh whenever no read is in progress. A bus reset ends a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | `rx_byte` holds a command code (write 0Fh, read AAh) |
| rx_valid | input | 1 | `rx_byte` holds an address or data byte |
| rx_byte | input | 8 | Byte received from the host |
| bus_rst | input | 1 | Bus reset pulse |
| rx_partial | input | 1 | Qualifies `bus_rst`: a byte was partly received |
| tx_next | input | 1 | The host has taken `tx_byte`; advance |
| auth_set | input | 1 | Set the authorization flag |
| blk_wp | input | NBLK | Write-protect setting per block |
| blk_eprom | input | NBLK | One-way (1 to 0 only) setting per block |
| mem_rdata | input | 8 | Array read data, one cycle after `mem_addr` |
| mem_addr | output | 16 | Array address of the current buffer slot |
| tx_byte | output | 8 | Byte to return to the host |

## Verification
The assertions assume that at most one of `cmd_valid`, `rx_valid` and `bus_rst` is high in any cycle. They also assume that no new data byte, command or bus reset arrives in the cycle right after a data byte, because that cycle is taken by the array lookup and merge. `tx_next` is only pulsed during a read. The stimulus tasks drive each event for exactly one cycle and then leave at least one idle cycle. Protection inputs are changed only between sequences.

// File: rtl/scpad_pkg.sv
package scpad_pkg;

  localparam int TA_W = 16;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_ADDR_LO,
    WS_ADDR_HI,
    WS_DATA,
    WS_FULL
  } wr_state_e;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ADDR_LO,
    RS_ADDR_HI,
    RS_STATUS,
    RS_DATA,
    RS_CRC_LO,
    RS_CRC_HI,
    RS_ONES
  } rd_phase_e;

  // reflected form of x^16+x^15+x^2+1
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/scpad_store.sv
module scpad_store #(
  parameter int DEPTH = 32,
  localparam int OFFW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            we,
  input  logic [OFFW-1:0] waddr,
  input  logic [7:0]      wdata,
  input  logic [OFFW-1:0] raddr,
  output logic [7:0]      rdata
);

  logic [7:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == OFFW'(g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= wdata;
    end
  end

  assign rdata = ent_q[raddr];

endmodule

// File: rtl/scpad_merge.sv
module scpad_merge #(
  parameter int NBLK = 11,
  parameter int IDXW = 4
) (
  input  logic [IDXW-1:0] blk_idx,
  input  logic [NBLK-1:0] blk_wp,
  input  logic [NBLK-1:0] blk_eprom,
  input  logic [7:0]      new_byte,
  input  logic [7:0]      old_byte,
  output logic [7:0]      merged,
  output logic            sel_wp,
  output logic            sel_ep
);

  localparam int NIDX = 1 << IDXW;

  logic [NIDX-1:0] wp_ext, ep_ext;

  for (genvar g = 0; g < NIDX; g++) begin : g_pad
    if (g < NBLK) begin : g_real
      assign wp_ext[g] = blk_wp[g];
      assign ep_ext[g] = blk_eprom[g];
    end else begin : g_none
      assign wp_ext[g] = 1'b0;
      assign ep_ext[g] = 1'b0;
    end
  end

  assign sel_wp = wp_ext[blk_idx];
  assign sel_ep = ep_ext[blk_idx];

  always_comb begin
    if (sel_wp)      merged = old_byte;
    else if (sel_ep) merged = old_byte & new_byte;
    else             merged = new_byte;
  end

endmodule

// File: rtl/scpad_rdseq.sv
module scpad_rdseq
  import scpad_pkg::*;
#(
  parameter int          OFFW   = 5,
  parameter logic [7:0]  RD_CMD = 8'hAA
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            start,
  input  logic            abort,
  input  logic            tx_next,
  input  logic [TA_W-1:0] ta,
  input  logic [7:0]      status,
  input  logic [7:0]      sp_rdata,
  output logic [OFFW-1:0] sp_raddr,
  output logic [7:0]      tx_byte
);

  rd_phase_e       phase_q, phase_d;
  logic [OFFW-1:0] roff_q, roff_d;
  logic [15:0]     crc_q, crc_d;

  always_comb begin
    case (phase_q)
      RS_ADDR_LO: tx_byte = ta[7:0];
      RS_ADDR_HI: tx_byte = ta[15:8];
      RS_STATUS:  tx_byte = status;
      RS_DATA:    tx_byte = sp_rdata;
      RS_CRC_LO:  tx_byte = ~crc_q[7:0];
      RS_CRC_HI:  tx_byte = ~crc_q[15:8];
      default:    tx_byte = 8'hFF;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    roff_d  = roff_q;
    crc_d   = crc_q;
    if (abort) begin
      phase_d = RS_IDLE;
    end else if (start) begin
      phase_d = RS_ADDR_LO;
      roff_d  = ta[OFFW-1:0];
      crc_d   = crc16_step(16'h0000, RD_CMD);
    end else if (tx_next) begin
      case (phase_q)
        RS_ADDR_LO: begin crc_d = crc16_step(crc_q, tx_byte); phase_d = RS_ADDR_HI; end
        RS_ADDR_HI: begin crc_d = crc16_step(crc_q, tx_byte); phase_d = RS_STATUS;  end
        RS_STATUS:  begin crc_d = crc16_step(crc_q, tx_byte); phase_d = RS_DATA;    end
        RS_DATA: begin
          crc_d = crc16_step(crc_q, tx_byte);
          if (roff_q == '1) phase_d = RS_CRC_LO;
          else              roff_d  = roff_q + 1'b1;
        end
        RS_CRC_LO: phase_d = RS_CRC_HI;
        RS_CRC_HI: phase_d = RS_ONES;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= RS_IDLE;
      roff_q  <= '0;
      crc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      roff_q  <= roff_d;
      crc_q   <= crc_d;
    end
  end

  assign sp_raddr = roff_q;

endmodule

// File: rtl/scpad_ctrl.sv
module scpad_ctrl
  import scpad_pkg::*;
#(
  parameter int         SP_BYTES  = 32,
  parameter int         NBLK      = 11,
  parameter int         MASK_BITS = 4,
  parameter int         BLK_SHIFT = 8,
  parameter logic [7:0] WR_CMD    = 8'h0F,
  parameter logic [7:0] RD_CMD    = 8'hAA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            rx_valid,
  input  logic [7:0]      rx_byte,
  input  logic            bus_rst,
  input  logic            rx_partial,
  input  logic            tx_next,
  input  logic            auth_set,
  input  logic [NBLK-1:0] blk_wp,
  input  logic [NBLK-1:0] blk_eprom,
  input  logic [7:0]      mem_rdata,
  output logic [15:0]     mem_addr,
  output logic [7:0]      tx_byte
);

  localparam int         OFFW    = $clog2(SP_BYTES);
  localparam int         KEEP_W  = TA_W - MASK_BITS;
  localparam int         IDXW    = KEEP_W - BLK_SHIFT;
  localparam logic [7:0] HI_MASK = 8'hFF >> MASK_BITS;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wr_state_e       wst_q, wst_d;
  logic [15:0]     ta_q, ta_d;
  logic [OFFW-1:0] woff_q, woff_d;
  logic [OFFW-1:0] eoff_q, eoff_d;
  logic            pf_q, pf_d;
  logic            aa_q, aa_d;
  logic            pend_q, pend_d;
  logic [7:0]      pbyte_q, pbyte_d;

  logic [7:0]      sp_wdata, sp_rdata, status;
  logic [OFFW-1:0] sp_raddr;
  logic            sel_wp, sel_ep;
  logic            rd_start, rd_abort;

  always_comb begin
    wst_d   = wst_q;
    ta_d    = ta_q;
    woff_d  = woff_q;
    eoff_d  = eoff_q;
    pf_d    = pf_q;
    aa_d    = aa_q;
    pend_d  = 1'b0;
    pbyte_d = pbyte_q;

    if (auth_set) aa_d = 1'b1;

    // merge cycle of a fully received data byte
    if (pend_q) begin
      eoff_d = woff_q;
      if (wst_q == WS_DATA) begin
        if (woff_q == OFFW'(SP_BYTES - 1)) wst_d  = WS_FULL;
        else                               woff_d = woff_q + 1'b1;
      end
    end

    if (bus_rst) begin
      wst_d = WS_IDLE;
      if (wst_q == WS_ADDR_LO || wst_q == WS_ADDR_HI) pf_d = 1'b1;
      if ((wst_q == WS_DATA || wst_q == WS_FULL) && rx_partial) pf_d = 1'b1;
    end else if (cmd_valid) begin
      if (rx_byte == WR_CMD) begin
        wst_d = WS_ADDR_LO;
        pf_d  = 1'b0;
        aa_d  = 1'b0;
      end else begin
        wst_d = WS_IDLE;
      end
    end else if (rx_valid) begin
      case (wst_q)
        WS_ADDR_LO: begin
          ta_d[7:0] = rx_byte;
          wst_d     = WS_ADDR_HI;
        end
        WS_ADDR_HI: begin
          ta_d[15:8] = rx_byte & HI_MASK;
          woff_d     = ta_q[OFFW-1:0];
          eoff_d     = ta_q[OFFW-1:0];
          wst_d      = WS_DATA;
        end
        WS_DATA: begin
          pend_d  = 1'b1;
          pbyte_d = rx_byte;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wst_q   <= WS_IDLE;
      ta_q    <= '0;
      woff_q  <= '0;
      eoff_q  <= '0;
      pf_q    <= 1'b1;
      aa_q    <= 1'b0;
      pend_q  <= 1'b0;
      pbyte_q <= '0;
    end else begin
      wst_q   <= wst_d;
      ta_q    <= ta_d;
      woff_q  <= woff_d;
      eoff_q  <= eoff_d;
      pf_q    <= pf_d;
      aa_q    <= aa_d;
      pend_q  <= pend_d;
      pbyte_q <= pbyte_d;
    end
  end

  assign mem_addr = {ta_q[15:OFFW], woff_q};

  always_comb begin
    status            = '0;
    status[OFFW-1:0]  = eoff_q;
    status[5]         = pf_q;
    status[7]         = aa_q;
  end

  scpad_merge #(
    .NBLK (NBLK),
    .IDXW (IDXW)
  ) u_merge (
    .blk_idx   (ta_q[BLK_SHIFT +: IDXW]),
    .blk_wp    (blk_wp),
    .blk_eprom (blk_eprom),
    .new_byte  (pbyte_q),
    .old_byte  (mem_rdata),
    .merged    (sp_wdata),
    .sel_wp    (sel_wp),
    .sel_ep    (sel_ep)
  );

  scpad_store #(
    .DEPTH (SP_BYTES)
  ) u_store (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .we     (pend_q),
    .waddr  (woff_q),
    .wdata  (sp_wdata),
    .raddr  (sp_raddr),
    .rdata  (sp_rdata)
  );

  assign rd_start = cmd_valid && !bus_rst && (rx_byte == RD_CMD);
  assign rd_abort = bus_rst || (cmd_valid && (rx_byte != RD_CMD));

  scpad_rdseq #(
    .OFFW   (OFFW),
    .RD_CMD (RD_CMD)
  ) u_rdseq (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .start    (rd_start),
    .abort    (rd_abort),
    .tx_next  (tx_next),
    .ta       (ta_q),
    .status   (status),
    .sp_rdata (sp_rdata),
    .sp_raddr (sp_raddr),
    .tx_byte  (tx_byte)
  );

endmodule

// File: rtl/scpad_ctrl_chk.sv
module scpad_ctrl_chk
  import scpad_pkg::*;
#(
  parameter int         MASK_BITS = 4,
  parameter int         OFFW      = 5,
  parameter logic [7:0] WR_CMD    = 8'h0F
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      wst,
  input logic            cmd_valid,
  input logic            rx_valid,
  input logic [7:0]      rx_byte,
  input logic            bus_rst,
  input logic            rx_partial,
  input logic [15:0]     ta,
  input logic            pf,
  input logic            aa,
  input logic            pend,
  input logic [OFFW-1:0] woff,
  input logic [7:0]      sp_wdata,
  input logic [7:0]      mem_rdata,
  input logic            sel_wp,
  input logic            sel_ep,
  input logic [7:0]      tx_byte
);

  p_addr_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wst == WS_ADDR_HI && rx_valid && !bus_rst && !cmd_valid) |=>
      (ta[15 -: MASK_BITS] == '0 && ta[15-MASK_BITS:8] == $past(rx_byte[7-MASK_BITS:0])));

  p_offset_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && wst == WS_DATA && woff != '1) |=> (woff == $past(woff) + 1'b1));

  p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !bus_rst && rx_byte == WR_CMD) |=> (!pf && !aa));

  p_short_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && (wst == WS_ADDR_LO || wst == WS_ADDR_HI)) |=> pf);

  p_partial_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && rx_partial && wst == WS_DATA) |=> pf);

  p_protect_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && sel_wp) |-> (sp_wdata == mem_rdata));

  p_one_way_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !sel_wp && sel_ep) |-> ((sp_wdata & ~mem_rdata) == 8'h00));

  p_idle_ones_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (tx_byte == 8'hFF));

endmodule

bind scpad_ctrl scpad_ctrl_chk #(
  .MASK_BITS (MASK_BITS),
  .OFFW      (OFFW),
  .WR_CMD    (WR_CMD)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .wst        (wst_q),
  .cmd_valid  (cmd_valid),
  .rx_valid   (rx_valid),
  .rx_byte    (rx_byte),
  .bus_rst    (bus_rst),
  .rx_partial (rx_partial),
  .ta         (ta_q),
  .pf         (pf_q),
  .aa         (aa_q),
  .pend       (pend_q),
  .woff       (woff_q),
  .sp_wdata   (sp_wdata),
  .mem_rdata  (mem_rdata),
  .sel_wp     (sel_wp),
  .sel_ep     (sel_ep),
  .tx_byte    (tx_byte)
);

// File: tb/test_scpad_ctrl.sv
module test_scpad_ctrl;

  localparam int         NBLK = 11;
  localparam logic [7:0] WR   = 8'h0F;
  localparam logic [7:0] RD   = 8'hAA;

  logic            clk;
  logic            rst_n;
  logic            cmd_valid, rx_valid, bus_rst, rx_partial, tx_next, auth_set;
  logic [7:0]      rx_byte;
  logic [NBLK-1:0] blk_wp, blk_eprom;
  logic [7:0]      mem_rdata;
  logic [15:0]     mem_addr;
  logic [7:0]      tx_byte;

  int checks = 0;
  int errors = 0;

  logic [7:0]  exp_sp [32];
  logic [15:0] exp_ta;
  logic [4:0]  exp_eoff;
  logic        exp_pf, exp_aa;

  scpad_ctrl i_scpad_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .bus_rst(bus_rst), .rx_partial(rx_partial),
    .tx_next(tx_next), .auth_set(auth_set), .blk_wp(blk_wp),
    .blk_eprom(blk_eprom), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .tx_byte(tx_byte)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) mem_rdata <= mem_fn(mem_addr);

  function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      logic fb;
      fb = r[0] ^ d[b];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse_cmd(input logic [7:0] code);
    @(negedge clk); cmd_valid = 1'b1; rx_byte = code;
    @(negedge clk); cmd_valid = 1'b0;
    if (code == WR) begin exp_pf = 1'b0; exp_aa = 1'b0; end
  endtask

  task automatic pulse_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_rst(input logic partial);
    @(negedge clk); bus_rst = 1'b1; rx_partial = partial;
    @(negedge clk); bus_rst = 1'b0; rx_partial = 1'b0;
  endtask

  function automatic logic [7:0] stored(input logic [15:0] a, input logic [7:0] b);
    int  idx;
    logic wp, ep;
    idx = int'(a[11:8]);
    wp  = (idx < NBLK) ? blk_wp[idx]    : 1'b0;
    ep  = (idx < NBLK) ? blk_eprom[idx] : 1'b0;
    if (wp)      return mem_fn(a);
    else if (ep) return mem_fn(a) & b;
    else         return b;
  endfunction

  // write command, two address bytes, then n data bytes from d
  task automatic write_seq(input logic [7:0] lo, input logic [7:0] hi,
                           input logic [7:0] d [8], input int n);
    int off;
    pulse_cmd(WR);
    pulse_byte(lo);
    pulse_byte(hi);
    exp_ta   = {4'h0, hi[3:0], lo};
    off      = int'(lo[4:0]);
    exp_eoff = lo[4:0];
    for (int k = 0; k < n; k++) begin
      pulse_byte(d[k]);
      if (off < 32) begin
        exp_sp[off] = stored({exp_ta[15:5], off[4:0]}, d[k]);
        exp_eoff    = off[4:0];
        off++;
      end
    end
  endtask

  task automatic read_check(input string req);
    logic [15:0] crc;
    pulse_cmd(RD);
    crc = crc_add(16'h0000, RD);
    check8({req, " addr lo"}, tx_byte, exp_ta[7:0]);
    crc = crc_add(crc, exp_ta[7:0]);
    @(negedge clk); tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
    check8({req, " addr hi"}, tx_byte, exp_ta[15:8]);
    crc = crc_add(crc, exp_ta[15:8]);
    @(negedge clk); tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
    check8({req, " R10 status"}, tx_byte, {exp_aa, 1'b0, exp_pf, exp_eoff});
    crc = crc_add(crc, {exp_aa, 1'b0, exp_pf, exp_eoff});
    for (int s = int'(exp_ta[4:0]); s < 32; s++) begin
      @(negedge clk); tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
      check8({req, " R8 data"}, tx_byte, exp_sp[s]);
      crc = crc_add(crc, exp_sp[s]);
    end
    @(negedge clk); tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
    check8("R9 crc lo", tx_byte, ~crc[7:0]);
    @(negedge clk); tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
    check8("R9 crc hi", tx_byte, ~crc[15:8]);
    for (int t = 0; t < 2; t++) begin
      @(negedge clk); tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
      check8("R9 trailing ones", tx_byte, 8'hFF);
    end
    pulse_rst(1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check8("R12 idle after reset", tx_byte, 8'hFF);
    read_check("R4 power-up");
  endtask

  task automatic t_plain;
    logic [7:0] d [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h0, 8'h0, 8'h0, 8'h0};
    write_seq(8'h10, 8'h00, d, 4);
    read_check("R2 R3 plain");
  endtask

  task automatic t_mask;
    logic [7:0] d [8] = '{8'hA5, 8'h5A, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    write_seq(8'h45, 8'hF1, d, 2);
    read_check("R1 masked");
  endtask

  task automatic t_protect;
    logic [7:0] d [8] = '{8'h00, 8'hFF, 8'h3C, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    blk_wp[2] = 1'b1;
    write_seq(8'h1C, 8'h02, d, 3);
    read_check("R6 R11 protected");
    blk_wp[2] = 1'b0;
  endtask

  task automatic t_eprom;
    logic [7:0] d [8] = '{8'hF0, 8'h0F, 8'hFF, 8'h00, 8'h0, 8'h0, 8'h0, 8'h0};
    blk_eprom[3] = 1'b1;
    write_seq(8'h00, 8'h03, d, 4);
    read_check("R7 one-way");
    blk_eprom[3] = 1'b0;
    blk_wp[4] = 1'b1; blk_eprom[4] = 1'b1;
    write_seq(8'h08, 8'h04, d, 2);
    read_check("R7 priority");
    blk_wp[4] = 1'b0; blk_eprom[4] = 1'b0;
  endtask

  task automatic t_full;
    logic [7:0] d [8] = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'h0, 8'h0, 8'h0, 8'h0};
    write_seq(8'h1E, 8'h00, d, 4);
    read_check("R2 overflow");
  endtask

  task automatic t_beyond;
    logic [7:0] d [8] = '{8'h99, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    blk_wp = '1;
    write_seq(8'h04, 8'h0B, d, 1);
    read_check("R11 beyond blocks");
    blk_wp = '0;
  endtask

  task automatic t_short;
    pulse_cmd(WR);
    pulse_byte(8'h33);
    exp_ta[7:0] = 8'h33;
    pulse_rst(1'b0);
    exp_pf = 1'b1;
    read_check("R4 short address");
  endtask

  task automatic t_partial;
    logic [7:0] d [8] = '{8'hC3, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    write_seq(8'h08, 8'h00, d, 1);
    pulse_rst(1'b1);
    exp_pf = 1'b1;
    read_check("R5 partial byte");
  endtask

  task automatic t_auth;
    logic [7:0] d [8] = '{8'h7E, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    @(negedge clk); auth_set = 1'b1;
    @(negedge clk); auth_set = 1'b0;
    exp_aa = 1'b1;
    read_check("R3 auth set");
    write_seq(8'h02, 8'h00, d, 1);
    read_check("R3 auth cleared");
  endtask

  task automatic t_abort;
    pulse_cmd(RD);
    @(negedge clk); tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
    @(negedge clk); tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
    check8("R10 status mid-read", tx_byte, {exp_aa, 1'b0, exp_pf, exp_eoff});
    pulse_rst(1'b0);
    check8("R12 read ended", tx_byte, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; rx_valid = 1'b0; bus_rst = 1'b0;
    rx_partial = 1'b0; tx_next = 1'b0; auth_set = 1'b0; rx_byte = '0;
    blk_wp = '0; blk_eprom = '0;
    for (int i = 0; i < 32; i++) exp_sp[i] = 8'h00;
    exp_ta = '0; exp_eoff = '0; exp_pf = 1'b1; exp_aa = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_plain;
    t_mask;
    t_protect;
    t_eprom;
    t_full;
    t_beyond;
    t_short;
    t_partial;
    t_auth;
    t_abort;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule